// File: doc/BRIEF.md
# Sign-Sign LMS Data-Level Tracker

This block keeps a running estimate of the amplitude at which a correctly decided data symbol arrives at the receiver slicer. Once per baud it is given a signed equalized sample and the hard decision the data slicer made for it. It folds the sample onto the positive side using the decided polarity, compares the result with the current level estimate, and reports one error bit. It then nudges the estimate by a fixed, programmable step toward the sample. Only the sign of the error and the sign of the data are used, so every update moves the estimate by exactly one step, up or down.

The estimate is held in a fractional accumulator that is wider than the sample. Its integer part is the reference level that a neighbouring phase detector or error slicer reads, together with the registered error bit. Software-set limits keep the accumulator inside a window, and it never wraps around. An enable input holds the estimate in place while error bits keep flowing. A synchronous reset loads a chosen starting level.

Top module: `sslms_dlev_adapt`

## Requirements
- R1: One clock edge with `srst` high makes `level_acc` equal `init_level` times 16, makes `level` equal `init_level`, and drives `out_valid` and `out_err_up` low.
- R2: The folded magnitude of a sample is `in_sample` when `in_decision` is 1 (a +1 symbol) and the negated sample when `in_decision` is 0 (a −1 symbol). It is computed one bit wider, so a sample of −128 decided as −1 folds to +128.
- R3: One cycle after an edge with `in_valid` high, `out_valid` is high for that one cycle. `out_err_up` is 1 exactly when the folded magnitude is strictly greater than the `level` in force at the sampling edge.
- R4: On an adapting sample, the accumulator goes up by one step when the error bit is 1 and down by one step when it is 0, before limiting.
- R5: The step is 2 to the power `step_sel` accumulator LSBs (1, 2, 4, 8 or 16). Codes 5 to 7 give the largest step, 16.
- R6: After an adapting update, `level_acc` is never above `acc_max` or below `acc_min`. An update that would cross a limit lands exactly on that limit.
- R7: When `adapt_en` is low, a valid sample still produces `out_valid` and a correct `out_err_up`, but `level_acc` keeps its value.
- R8: In a cycle with `in_valid` low, `level_acc` keeps its value, and `out_valid` is low one cycle later.
- R9: When `srst` and `in_valid` are high at the same edge, the reset load of R1 takes effect and the sample is discarded.
- R10: `level` is always the upper 8 bits of `level_acc`, which means the accumulator divided by 16 and rounded toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Baud-rate clock |
| srst | input | 1 | Synchronous reset, active high; loads the initial level |
| in_valid | input | 1 | Sample and decision are present this cycle |
| in_sample | input | 8 | Equalized sample, two's complement |
| in_decision | input | 1 | Sliced symbol: 1 means +1, 0 means −1 |
| adapt_en | input | 1 | 1 lets the level move; 0 holds it |
| step_sel | input | 3 | Step exponent, 0 to 4; larger codes act as 4 |
| init_level | input | 8 | Level loaded by reset, two's complement |
| acc_min | input | 12 | Lower accumulator limit, two's complement |
| acc_max | input | 12 | Upper accumulator limit, two's complement |
| out_valid | output | 1 | Error bit is valid this cycle |
| out_err_up | output | 1 | 1 when the folded sample was above the level |
| level | output | 8 | Reference level, integer part of the accumulator |
| level_acc | output | 12 | Full accumulator, 4 fractional bits |

## Verification
Two things can happen in the same cycle: a step-sized update and limiting, and a reset and a valid sample. For the first, the bench sets a narrow window with the largest step and repeatedly drives samples that push the level toward each limit. The accumulator must stop exactly on the limit, must not overshoot or wrap, and must then stay there. For the second, the bench drives reset together with a sample that would raise the level. It expects the new initial level, no valid flag, and no trace of the sample.

// File: rtl/sslms_dlev_pkg.sv
package sslms_dlev_pkg;

    // Default geometry shared by the tracker and its bench.
    localparam int DLEV_W_DEF  = 8;
    localparam int FRAC_W_DEF  = 4;
    localparam int SEL_W_DEF   = 3;
    localparam int MAX_SEL_DEF = 4;

    // Direction of a sign-sign update.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dlev_dir_e;

endpackage

// File: rtl/dlev_err_slicer.sv
module dlev_err_slicer #(
    parameter int DLEV_W = 8
) (
    input  logic signed [DLEV_W-1:0] sample,
    input  logic                     decision,
    input  logic signed [DLEV_W-1:0] ref_level,
    output logic                     err_up
);
    localparam int MAG_W = DLEV_W + 1;

    logic signed [MAG_W-1:0] sample_ext;
    logic signed [MAG_W-1:0] folded;
    logic signed [MAG_W-1:0] ref_ext;

    always_comb begin
        sample_ext = MAG_W'(sample);
        ref_ext    = MAG_W'(ref_level);
        // Fold the sample onto the +1 side using the decided polarity.
        folded     = decision ? sample_ext : -sample_ext;
        // Error is level minus magnitude; report when it is negative.
        err_up     = (folded > ref_ext);
    end
endmodule

// File: rtl/dlev_step_update.sv
module dlev_step_update #(
    parameter int ACC_W   = 12,
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 4
) (
    input  logic signed [ACC_W-1:0] acc_cur,
    input  logic                    dir_up,
    input  logic [SEL_W-1:0]        step_sel,
    input  logic signed [ACC_W-1:0] lim_min,
    input  logic signed [ACC_W-1:0] lim_max,
    output logic signed [ACC_W-1:0] acc_nxt
);
    import sslms_dlev_pkg::*;

    localparam int WIDE_W = ACC_W + 1;

    logic [SEL_W-1:0]         sel_eff;
    logic signed [WIDE_W-1:0] step_val;
    logic signed [WIDE_W-1:0] raw_sum;
    logic signed [WIDE_W-1:0] min_ext;
    logic signed [WIDE_W-1:0] max_ext;

    always_comb begin
        sel_eff  = (step_sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : step_sel;
        step_val = $signed(WIDE_W'(1) << sel_eff);
        min_ext  = WIDE_W'(lim_min);
        max_ext  = WIDE_W'(lim_max);
        if (dlev_dir_e'(dir_up) == DIR_UP) begin
            raw_sum = WIDE_W'(acc_cur) + step_val;
        end else begin
            raw_sum = WIDE_W'(acc_cur) - step_val;
        end
        if (raw_sum > max_ext) begin
            acc_nxt = lim_max;
        end else if (raw_sum < min_ext) begin
            acc_nxt = lim_min;
        end else begin
            acc_nxt = raw_sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/sslms_dlev_adapt.sv
module sslms_dlev_adapt #(
    parameter int DLEV_W  = sslms_dlev_pkg::DLEV_W_DEF,
    parameter int FRAC_W  = sslms_dlev_pkg::FRAC_W_DEF,
    parameter int SEL_W   = sslms_dlev_pkg::SEL_W_DEF,
    parameter int MAX_SEL = sslms_dlev_pkg::MAX_SEL_DEF,
    localparam int ACC_W  = DLEV_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     srst,
    input  logic                     in_valid,
    input  logic signed [DLEV_W-1:0] in_sample,
    input  logic                     in_decision,
    input  logic                     adapt_en,
    input  logic [SEL_W-1:0]         step_sel,
    input  logic signed [DLEV_W-1:0] init_level,
    input  logic signed [ACC_W-1:0]  acc_min,
    input  logic signed [ACC_W-1:0]  acc_max,
    output logic                     out_valid,
    output logic                     out_err_up,
    output logic signed [DLEV_W-1:0] level,
    output logic signed [ACC_W-1:0]  level_acc
);
    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic                    vld;
        logic                    err;
    } trk_state_t;

    trk_state_t state_d, state_q;

    logic                    slice_err_d;
    logic signed [ACC_W-1:0] upd_acc_d;
    logic signed [DLEV_W-1:0] ref_q;

    assign ref_q = state_q.acc[ACC_W-1 -: DLEV_W];

    dlev_err_slicer #(
        .DLEV_W (DLEV_W)
    ) u_slicer (
        .sample    (in_sample),
        .decision  (in_decision),
        .ref_level (ref_q),
        .err_up    (slice_err_d)
    );

    dlev_step_update #(
        .ACC_W   (ACC_W),
        .SEL_W   (SEL_W),
        .MAX_SEL (MAX_SEL)
    ) u_update (
        .acc_cur  (state_q.acc),
        .dir_up   (slice_err_d),
        .step_sel (step_sel),
        .lim_min  (acc_min),
        .lim_max  (acc_max),
        .acc_nxt  (upd_acc_d)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        if (srst) begin
            state_d.acc = {init_level, {FRAC_W{1'b0}}};
            state_d.err = 1'b0;
        end else if (in_valid) begin
            state_d.vld = 1'b1;
            state_d.err = slice_err_d;
            if (adapt_en) begin
                state_d.acc = upd_acc_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign out_valid  = state_q.vld;
    assign out_err_up = state_q.err;
    assign level      = ref_q;
    assign level_acc  = state_q.acc;
endmodule

// File: rtl/sslms_dlev_adapt_chk.sv
module sslms_dlev_adapt_chk #(
    parameter int DLEV_W = 8,
    parameter int ACC_W  = 12
) (
    input logic                     clk,
    input logic                     srst,
    input logic                     in_valid,
    input logic                     adapt_en,
    input logic signed [DLEV_W-1:0] init_level,
    input logic signed [ACC_W-1:0]  acc_min,
    input logic signed [ACC_W-1:0]  acc_max,
    input logic                     out_valid,
    input logic                     out_err_up,
    input logic signed [ACC_W-1:0]  level_acc
);
    localparam int FRAC_W = ACC_W - DLEV_W;

    // R1 and R9: reset loads the initial level and clears the outputs.
    a_r1_reset_load: assert property (@(posedge clk)
        srst |=> (level_acc == {$past(init_level), {FRAC_W{1'b0}}}) && !out_valid && !out_err_up);

    // R3: a valid sample produces a one-cycle valid flag.
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (srst)
        (in_valid && !srst) |=> out_valid);

    // R8: no sample, no flag.
    a_r8_no_valid: assert property (@(posedge clk) disable iff (srst)
        (!in_valid && !srst) |=> !out_valid);

    // R7 and R8: the accumulator holds unless an adapting sample arrives.
    a_r7_hold: assert property (@(posedge clk) disable iff (srst)
        (!srst && !(in_valid && adapt_en)) |=> $stable(level_acc));

    // R6: an adapting update lands inside the window.
    a_r6_within_limits: assert property (@(posedge clk) disable iff (srst)
        (!srst && in_valid && adapt_en) |=>
            (level_acc <= $past(acc_max)) && (level_acc >= $past(acc_min)));

    // R4: the move follows the reported error direction.
    a_r4_direction: assert property (@(posedge clk) disable iff (srst)
        (!srst && in_valid && adapt_en &&
         level_acc >= acc_min && level_acc <= acc_max) |=>
            (out_err_up ? (level_acc >= $past(level_acc)) : (level_acc <= $past(level_acc))));

    // R5: no move exceeds the largest step.
    a_r5_step_bound: assert property (@(posedge clk) disable iff (srst)
        (!srst && in_valid && adapt_en &&
         level_acc >= acc_min && level_acc <= acc_max) |=>
            ((level_acc - $past(level_acc)) <= 16) && (($past(level_acc) - level_acc) <= 16));
endmodule

bind sslms_dlev_adapt sslms_dlev_adapt_chk #(
    .DLEV_W (DLEV_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk        (clk),
    .srst       (srst),
    .in_valid   (in_valid),
    .adapt_en   (adapt_en),
    .init_level (init_level),
    .acc_min    (acc_min),
    .acc_max    (acc_max),
    .out_valid  (out_valid),
    .out_err_up (out_err_up),
    .level_acc  (level_acc)
);

// File: tb/sslms_dlev_adapt_tb.sv
`timescale 1ns/1ps
module sslms_dlev_adapt_tb;

    logic              clk = 1'b0;
    logic              srst;
    logic              in_valid;
    logic signed [7:0] in_sample;
    logic              in_decision;
    logic              adapt_en;
    logic [2:0]        step_sel;
    logic signed [7:0] init_level;
    logic signed [11:0] acc_min;
    logic signed [11:0] acc_max;
    logic              out_valid;
    logic              out_err_up;
    logic signed [7:0] level;
    logic signed [11:0] level_acc;

    int n_checks = 0;
    int n_fail   = 0;
    int model_acc;
    int lim_lo;
    int lim_hi;

    always #10 clk = ~clk;

    sslms_dlev_adapt u_dut (
        .clk         (clk),
        .srst        (srst),
        .in_valid    (in_valid),
        .in_sample   (in_sample),
        .in_decision (in_decision),
        .adapt_en    (adapt_en),
        .step_sel    (step_sel),
        .init_level  (init_level),
        .acc_min     (acc_min),
        .acc_max     (acc_max),
        .out_valid   (out_valid),
        .out_err_up  (out_err_up),
        .level       (level),
        .level_acc   (level_acc)
    );

    typedef struct packed {
        logic signed [7:0] smp;
        logic              dec;
        logic              adp;
        logic [2:0]        sel;
        logic              exp_err;
    } vec_t;

    // Level starts at 32 (accumulator 512); expected error bits worked by hand.
    localparam vec_t VECS [10] = '{
        '{ 8'sd40,   1'b1, 1'b1, 3'd4, 1'b1 },  // R2 R3: 40 > 32
        '{ -8'sd50,  1'b0, 1'b1, 3'd4, 1'b1 },  // R2: -1 symbol folds to 50 > 33
        '{ 8'sd10,   1'b1, 1'b1, 3'd2, 1'b0 },  // R4: down by 4
        '{ -8'sd20,  1'b0, 1'b1, 3'd0, 1'b0 },  // R5: step 1
        '{ 8'sd20,   1'b0, 1'b1, 3'd7, 1'b0 },  // R5: code 7 acts as 16
        '{ 8'sd33,   1'b1, 1'b1, 3'd3, 1'b1 },  // R3: 33 > 32
        '{ 8'sd33,   1'b1, 1'b0, 3'd4, 1'b0 },  // R3: 33 equals level 33; R7 frozen
        '{ -8'sd128, 1'b0, 1'b1, 3'd4, 1'b1 },  // R2: -128 as -1 folds to +128
        '{ 8'sd127,  1'b1, 1'b1, 3'd1, 1'b1 },  // R5: step 2
        '{ -8'sd128, 1'b1, 1'b1, 3'd4, 1'b0 }   // R2: -128 as +1 stays negative
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_next(input int acc, input bit up, input int sel);
        int st;
        int nx;
        st = 1 << ((sel > 4) ? 4 : sel);
        nx = up ? acc + st : acc - st;
        if (nx > lim_hi) nx = lim_hi;
        if (nx < lim_lo) nx = lim_lo;
        return nx;
    endfunction

    function automatic bit model_err(input int s, input bit d);
        int mag;
        mag = d ? s : -s;
        return mag > (model_acc >>> 4);
    endfunction

    task automatic set_limits(input int lo, input int hi);
        @(negedge clk);
        lim_lo  = lo;
        lim_hi  = hi;
        acc_min = 12'(lo);
        acc_max = 12'(hi);
    endtask

    task automatic drive(input logic signed [7:0] s, input logic d, input logic a,
                         input logic [2:0] sel, input logic e, input string req);
        @(negedge clk);
        in_valid    = 1'b1;
        in_sample   = s;
        in_decision = d;
        adapt_en    = a;
        step_sel    = sel;
        @(negedge clk);
        in_valid = 1'b0;
        if (a) model_acc = model_next(model_acc, e, int'(sel));
        check(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
        check(out_err_up == e, {req, " err"}, int'(out_err_up), int'(e));
        check(int'(level_acc) == model_acc, {req, " acc"}, int'(level_acc), model_acc);
        check(int'(level) == (model_acc >>> 4), "R10 level", int'(level), model_acc >>> 4);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        srst = 1'b1; in_valid = 1'b0; in_sample = '0; in_decision = 1'b0;
        adapt_en = 1'b0; step_sel = '0; init_level = 8'sd32;
        lim_lo = 64; lim_hi = 1024;
        acc_min = 12'sd64; acc_max = 12'sd1024;
        repeat (3) @(negedge clk);
        srst = 1'b0;
        model_acc = 512;
        // R1: reset state
        check(int'(level_acc) == 512, "R1 acc", int'(level_acc), 512);
        check(int'(level) == 32, "R1 level", int'(level), 32);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_err_up == 1'b0, "R1 err", int'(out_err_up), 0);

        foreach (VECS[i]) begin
            drive(VECS[i].smp, VECS[i].dec, VECS[i].adp, VECS[i].sel, VECS[i].exp_err, "R3 R4 vec");
        end

        // R6: upper limit reached with the largest step
        set_limits(64, 560);
        for (int k = 0; k < 3; k++) begin
            drive(8'sd100, 1'b1, 1'b1, 3'd4, model_err(100, 1'b1), "R6 upper");
        end
        check(int'(level_acc) == 560, "R6 pinned at max", int'(level_acc), 560);

        // R6: lower limit
        set_limits(500, 560);
        for (int k = 0; k < 5; k++) begin
            drive(8'sd0, 1'b1, 1'b1, 3'd4, model_err(0, 1'b1), "R6 lower");
        end
        check(int'(level_acc) == 500, "R6 pinned at min", int'(level_acc), 500);

        // R7: frozen level, error still reported
        drive(8'sd120, 1'b1, 1'b0, 3'd4, 1'b1, "R7 freeze");
        check(int'(level_acc) == 500, "R7 held", int'(level_acc), 500);

        // R8: idle cycles
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R8 no valid", int'(out_valid), 0);
        check(int'(level_acc) == 500, "R8 held", int'(level_acc), 500);

        // R9: reset together with a sample
        @(negedge clk);
        srst = 1'b1; init_level = 8'sd10;
        in_valid = 1'b1; in_sample = 8'sd100; in_decision = 1'b1; adapt_en = 1'b1;
        @(negedge clk);
        srst = 1'b0; in_valid = 1'b0;
        check(int'(level_acc) == 160, "R9 acc", int'(level_acc), 160);
        check(out_valid == 1'b0, "R9 valid", int'(out_valid), 0);
        check(int'(level) == 10, "R9 level", int'(level), 10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule